// File: doc/BRIEF.md
# Single/Double Precision Floating-Point Format Converter

This block converts a binary floating-point operand between the 32-bit single format and the 64-bit double format, in either direction, chosen per operation by a direction input. Widening (single to double) is exact for every input, including single subnormals, which are renormalized into the double format. Narrowing (double to single) rounds to nearest-even. Values too large for a single become infinity, and values below the normal single range are flushed to a signed zero.

NaNs have their own path. In normal operation a NaN keeps its sign, is made quiet, and carries as much of its payload as the destination mantissa can hold. When the default-NaN input is set, any NaN is replaced by the canonical quiet NaN of the destination format. The result is registered, so each accepted operand produces one result one clock later, together with a valid strobe.

Top module: `fp_width_conv`

## Requirements
- R1: With `in_narrow`=0, a finite single in `in_op[31:0]`, normal or subnormal, gives the double of exactly the same value in `out_res`. Single subnormals are renormalized. Bits `in_op[63:32]` have no effect.
- R2: With `in_narrow`=0, a single zero or infinity gives the double zero or infinity of the same sign.
- R3: With `in_dflt_nan`=1, any NaN input gives the canonical quiet NaN of the destination format: `64'h7FF8_0000_0000_0000` when widening and `32'h7FC0_0000` in `out_res[31:0]` when narrowing. `in_dflt_nan` has no effect on inputs that are not NaN.
- R4: When widening a NaN with `in_dflt_nan`=0, the result has:
  - bit 63 equal to the input sign (bit 31);
  - bits 62:52 all ones;
  - bit 51 set;
  - bits 50:29 equal to the input mantissa bits 21:0;
  - bits 28:0 zero.
- R5: When narrowing a NaN with `in_dflt_nan`=0, the single result has:
  - bit 31 equal to the input sign (bit 63);
  - bits 30:23 all ones;
  - bit 22 set;
  - bits 21:0 equal to the double mantissa bits 50:29.
- R6: When narrowing a double whose biased exponent E is in 897..1150, the single has biased exponent E-896. Its mantissa is double mantissa bits 51:29, rounded to nearest-even on guard bit 28 and sticky bits 27:0. A carry out of the mantissa increments the exponent.
- R7: Narrowing gives a same-signed single infinity (`8'hFF` exponent, zero mantissa) in three cases: a double infinity, E above 1150, or a rounding carry that reaches exponent 255.
- R8: Narrowing a double with E below 897 (zeros and subnormals included) gives a same-signed single zero. This is decided before rounding.
- R9: A narrowed result is placed in `out_res[31:0]`, and `out_res[63:32]` is zero.
- R10: `out_valid` equals `in_valid` from the previous cycle. `out_res` takes a new value one cycle after a cycle with `in_valid`=1 and holds otherwise. Reset clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_narrow | input | 1 | 1: double to single, 0: single to double |
| in_dflt_nan | input | 1 | 1: NaN results are the canonical NaN |
| in_op | input | 64 | Operand: a double, or a single in bits 31:0 |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_res | output | 64 | Result: a double, or a single in bits 31:0 |

## Verification
Every result is due exactly one clock edge after the edge that samples its operand, because the only register on the path is the output register. The bench drives each operand at a falling edge and compares `out_valid` and `out_res` at the next falling edge, one rising edge later and clear of it. Idle cycles are checked at the same offset to confirm that `out_res` holds and `out_valid` is low. Expected values come from the bench's own arithmetic: real-number scaling for widening, and an integer remainder-versus-half comparison for narrowing.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    localparam int SP_W       = 32;
    localparam int SP_EXP_W   = 8;
    localparam int SP_MAN_W   = 23;
    localparam int DP_W       = 64;
    localparam int DP_EXP_W   = 11;
    localparam int DP_MAN_W   = 52;
    localparam int MAN_DROP   = DP_MAN_W - SP_MAN_W;          // 29
    localparam int BIAS_DIFF  = 1023 - 127;                   // 896
    localparam int SP_EMAX    = (1 << SP_EXP_W) - 2;          // 254

    localparam logic [DP_W-1:0] DP_QNAN = 64'h7FF8_0000_0000_0000;
    localparam logic [SP_W-1:0] SP_QNAN = 32'h7FC0_0000;

    typedef struct packed {
        logic            vld;
        logic [DP_W-1:0] res;
    } fpc_state_t;
endpackage

// File: rtl/fpc_msb.sv
module fpc_msb #(
    parameter int W  = 23,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] pos
);
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) pos = IW'(i);
        end
    end
endmodule

// File: rtl/fpc_widen.sv
module fpc_widen
    import fpc_pkg::*;
(
    input  logic [SP_W-1:0] src,
    input  logic            dflt_nan,
    output logic [DP_W-1:0] dst
);
    localparam int PW = $clog2(SP_MAN_W);

    logic                sgn;
    logic [SP_EXP_W-1:0] bexp;
    logic [SP_MAN_W-1:0] frac;
    logic [PW-1:0]       top_pos;
    logic [SP_MAN_W-1:0] norm_frac;
    logic [DP_EXP_W-1:0] sub_exp;

    assign sgn  = src[SP_W-1];
    assign bexp = src[SP_W-2 -: SP_EXP_W];
    assign frac = src[SP_MAN_W-1:0];

    fpc_msb #(.W(SP_MAN_W), .IW(PW)) u_msb (
        .vec (frac),
        .pos (top_pos)
    );

    // Leading one shifted out above bit 22; exponent of 2^(pos-149).
    assign norm_frac = frac << (PW'(SP_MAN_W) - top_pos);
    assign sub_exp   = DP_EXP_W'(BIAS_DIFF - 22) + DP_EXP_W'(top_pos);

    always_comb begin
        if (bexp == '1) begin
            if (frac != '0)
                dst = dflt_nan ? DP_QNAN
                               : {sgn, {DP_EXP_W{1'b1}}, 1'b1, frac[SP_MAN_W-2:0], {MAN_DROP{1'b0}}};
            else
                dst = {sgn, {DP_EXP_W{1'b1}}, {DP_MAN_W{1'b0}}};
        end else if (bexp == '0) begin
            if (frac == '0)
                dst = {sgn, {(DP_W-1){1'b0}}};
            else
                dst = {sgn, sub_exp, norm_frac, {MAN_DROP{1'b0}}};
        end else begin
            dst = {sgn, DP_EXP_W'(bexp) + DP_EXP_W'(BIAS_DIFF), frac, {MAN_DROP{1'b0}}};
        end
    end
endmodule

// File: rtl/fpc_narrow.sv
module fpc_narrow
    import fpc_pkg::*;
(
    input  logic [DP_W-1:0] src,
    input  logic            dflt_nan,
    output logic [SP_W-1:0] dst
);
    logic                      sgn;
    logic [DP_EXP_W-1:0]       bexp;
    logic [DP_MAN_W-1:0]       frac;
    logic [SP_MAN_W-1:0]       keep;
    logic                      guard_b;
    logic                      sticky_b;
    logic                      rnd_up;
    logic [SP_EXP_W-1:0]       rebias;
    logic [SP_W-2:0]           packed_mag;

    assign sgn      = src[DP_W-1];
    assign bexp     = src[DP_W-2 -: DP_EXP_W];
    assign frac     = src[DP_MAN_W-1:0];
    assign keep     = frac[DP_MAN_W-1 -: SP_MAN_W];
    assign guard_b  = frac[MAN_DROP-1];
    assign sticky_b = |frac[MAN_DROP-2:0];
    assign rnd_up   = guard_b & (sticky_b | keep[0]);
    assign rebias   = bexp[SP_EXP_W-1:0] - SP_EXP_W'(BIAS_DIFF);
    // Mantissa carry ripples straight into the exponent field.
    assign packed_mag = {rebias, keep} + (SP_W-1)'(rnd_up);

    always_comb begin
        if (bexp == '1) begin
            if (frac != '0)
                dst = dflt_nan ? SP_QNAN
                               : {sgn, {SP_EXP_W{1'b1}}, 1'b1, frac[DP_MAN_W-2 -: SP_MAN_W-1]};
            else
                dst = {sgn, {SP_EXP_W{1'b1}}, {SP_MAN_W{1'b0}}};
        end else if (bexp < DP_EXP_W'(BIAS_DIFF + 1)) begin
            dst = {sgn, {(SP_W-1){1'b0}}};
        end else if (bexp > DP_EXP_W'(BIAS_DIFF + SP_EMAX)) begin
            dst = {sgn, {SP_EXP_W{1'b1}}, {SP_MAN_W{1'b0}}};
        end else begin
            dst = {sgn, packed_mag};
        end
    end
endmodule

// File: rtl/fp_width_conv.sv
module fp_width_conv
    import fpc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_narrow,
    input  logic            in_dflt_nan,
    input  logic [DP_W-1:0] in_op,
    output logic            out_valid,
    output logic [DP_W-1:0] out_res
);
    logic [DP_W-1:0] wide_res;
    logic [SP_W-1:0] slim_res;
    fpc_state_t      st_d, st_q;

    fpc_widen u_widen (
        .src      (in_op[SP_W-1:0]),
        .dflt_nan (in_dflt_nan),
        .dst      (wide_res)
    );

    fpc_narrow u_narrow (
        .src      (in_op),
        .dflt_nan (in_dflt_nan),
        .dst      (slim_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid)
            st_d.res = in_narrow ? {{(DP_W-SP_W){1'b0}}, slim_res} : wide_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_res   = st_q.res;
endmodule

// File: rtl/fp_width_conv_chk.sv
module fp_width_conv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_narrow,
    input logic        in_dflt_nan,
    input logic [63:0] in_op,
    input logic        out_valid,
    input logic [63:0] out_res
);
    logic nan32, nan64;
    assign nan32 = (in_op[30:23] == 8'hFF) && (in_op[22:0] != '0);
    assign nan64 = (in_op[62:52] == 11'h7FF) && (in_op[51:0] != '0);

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_res));
    // R9
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_narrow) |=> (out_res[63:32] == 32'h0));
    // R3
    narrow_dflt_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_narrow && in_dflt_nan && nan64) |=> (out_res == 64'h7FC0_0000));
    // R4
    widen_nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_narrow && !in_dflt_nan && nan32)
        |=> (out_res[51] && (out_res[63] == $past(in_op[31]))));
    // R5
    narrow_nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_narrow && !in_dflt_nan && nan64)
        |=> (out_res[22] && (out_res[31] == $past(in_op[63]))));
endmodule

bind fp_width_conv fp_width_conv_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_narrow   (in_narrow),
    .in_dflt_nan (in_dflt_nan),
    .in_op       (in_op),
    .out_valid   (out_valid),
    .out_res     (out_res)
);

// File: tb/fp_width_conv_tb.sv
module fp_width_conv_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_narrow = 1'b0;
    logic        in_dflt_nan = 1'b0;
    logic [63:0] in_op = '0;
    logic        out_valid;
    logic [63:0] out_res;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    fp_width_conv u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_narrow(in_narrow),
        .in_dflt_nan(in_dflt_nan), .in_op(in_op), .out_valid(out_valid), .out_res(out_res)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: got %0d cycles exp below %0d", cycles, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] widen_exp(input logic [31:0] v, input logic dn);
        logic s; logic [7:0] e; logic [22:0] m; real val;
        s = v[31]; e = v[30:23]; m = v[22:0];
        if (e == 8'hFF) begin
            if (m != 0)
                return dn ? 64'h7FF8_0000_0000_0000 : {s, 11'h7FF, 1'b1, m[21:0], 29'b0};
            return {s, 11'h7FF, 52'b0};
        end
        if (e == 0) val = real'(m) * (2.0 ** (-149.0));
        else        val = real'(int'(m) + 8388608) * (2.0 ** (real'(int'(e)) - 150.0));
        if (s) val = -val;
        return $realtobits(val);
    endfunction

    function automatic logic [63:0] narrow_exp(input logic [63:0] v, input logic dn);
        logic s; logic [10:0] ex; logic [51:0] m;
        logic [52:0] man; logic [24:0] q; logic [28:0] rem; int e;
        s = v[63]; ex = v[62:52]; m = v[51:0];
        if (ex == 11'h7FF) begin
            if (m != 0)
                return dn ? 64'h7FC0_0000 : {32'b0, s, 8'hFF, 1'b1, m[50:29]};
            return {32'b0, s, 8'hFF, 23'b0};
        end
        e = int'(ex) - 896;
        if (e < 1)   return {32'b0, s, 31'b0};
        if (e > 254) return {32'b0, s, 8'hFF, 23'b0};
        man = {1'b1, m};
        q   = {1'b0, man[52:29]};
        rem = man[28:0];
        if (rem > 29'h1000_0000 || (rem == 29'h1000_0000 && q[0])) q = q + 1;
        if (q[24]) begin e = e + 1; q = q >> 1; end
        if (e > 254) return {32'b0, s, 8'hFF, 23'b0};
        return {32'b0, s, 8'(e), q[22:0]};
    endfunction

    task automatic run_one(input logic nar, input logic dn, input logic [63:0] op,
                           input logic [63:0] exp, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_narrow = nar; in_dflt_nan = dn; in_op = op;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, out_res, exp);
        if (out_valid !== 1'b1) check("R10 valid", {63'b0, out_valid}, 64'd1);
    endtask

    logic [22:0] wpat [8];
    logic [51:0] npat [8];

    initial begin
        wpat = '{23'h0, 23'h1, 23'h7FFFFF, 23'h400000, 23'h200001, 23'h155555, 23'h000400, 23'h2AAAAA};
        // zero, all ones, tie even, tie odd, above half, below half, mixed, mixed
        npat = '{52'h0, 52'hF_FFFF_FFFF_FFFF, 52'h0_0000_1000_0000, 52'h0_0000_3000_0000,
                 52'h0_0000_1000_0001, 52'h0_0000_0FFF_FFFF, 52'h5_5555_5555_5555, 52'hA_BCDE_F012_3456};

        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset res", out_res, 64'h0);
        check("R10 reset valid", {63'b0, out_valid}, 64'h0);
        rst_n = 1'b1;

        // Widening sweep: R1 R2 R3 R4, upper input bits carry garbage
        for (int s = 0; s < 2; s++)
            for (int e = 0; e < 256; e++)
                for (int k = 0; k < 8; k++)
                    for (int dn = 0; dn < 2; dn++) begin
                        logic [31:0] v; string tag;
                        v = {s[0], e[7:0], wpat[k]};
                        if (e == 255 && wpat[k] != 0) tag = dn ? "R3 widen" : "R4 widen";
                        else if (e == 255 || (e == 0 && wpat[k] == 0)) tag = "R2 widen";
                        else tag = "R1 widen";
                        run_one(1'b0, dn[0], {32'hDEAD_BEEF ^ {e[7:0], 24'h0}, v}, widen_exp(v, dn[0]), tag);
                    end

        // Narrowing sweep: R3 R5 R6 R7 R8 R9
        for (int s = 0; s < 2; s++)
            for (int ei = 0; ei < 285; ei++)
                for (int k = 0; k < 8; k++)
                    for (int dn = 0; dn < 2; dn++) begin
                        int ex; logic [63:0] v; string tag;
                        if (ei < 281)      ex = 880 + ei;
                        else if (ei == 281) ex = 0;
                        else if (ei == 282) ex = 1;
                        else if (ei == 283) ex = 2046;
                        else               ex = 2047;
                        v = {s[0], 11'(ex), npat[k]};
                        if (ex == 2047 && npat[k] != 0) tag = dn ? "R3 narrow R9" : "R5 narrow R9";
                        else if (ex == 2047 || ex > 1150) tag = "R7 narrow R9";
                        else if (ex < 897) tag = "R8 narrow R9";
                        else tag = "R6 narrow R9";
                        run_one(1'b1, dn[0], v, narrow_exp(v, dn[0]), tag);
                    end

        // R7: rounding carry into exponent 255
        run_one(1'b1, 1'b0, {1'b0, 11'd1150, 52'hF_FFFF_F000_0000}, 64'h7F80_0000, "R7 round to inf");
        // R6: carry increments exponent
        run_one(1'b1, 1'b0, {1'b1, 11'd1000, 52'hF_FFFF_F000_0000},
                {32'b0, 1'b1, 8'(1000 - 896 + 1), 23'b0}, "R6 carry");

        // R10: output holds while in_valid is low
        for (int i = 0; i < 4; i++) begin
            logic [63:0] held;
            held = out_res;
            @(negedge clk);
            in_valid = 1'b0; in_narrow = i[0]; in_op = {32'h1234_5678, 32'h3F80_0001} + 64'(i);
            @(negedge clk);
            check("R10 hold", out_res, held);
            check("R10 idle valid", {63'b0, out_valid}, 64'h0);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule